// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-level configuration engine of a legacy plug-and-play expansion card. The host reaches it through three byte-wide I/O locations. A fixed index port selects an internal register. A fixed write port carries data into that register. A read port returns register contents, and the host can move that port's address. The block keeps the card select number (CSN), the selected logical device and the current card state. It executes the configuration-control, wake, CSN and logical-device commands.

The card states are Wait-for-Key, Sleep, Isolation and Config. Two inputs stand in for parts that live elsewhere. A one-cycle `key_ok` strobe reports that the initiation key was recognised. A `iso_fail` strobe reports that the card lost a serial-identification bit comparison. Commands that act on other logic are reported as one-cycle pulses: the logical-device reset, the resource-pointer clear and the identification-compare request. The per-device resource registers are outside this block.

Top module: `pnp_card_cfg`

## Requirements
- R1: After reset the state is Wait-for-Key, the CSN is 0x00, the selected device is 0 and the read port sits at address 0x003. The `card_state` encoding is 0 Wait-for-Key, 1 Sleep, 2 Isolation, 3 Config.
- R2: `key_ok` moves the card from Wait-for-Key to Sleep and has no effect in any other state. While the card is in Wait-for-Key, every data write and every read is ignored.
- R3: A write strobe to address 0x279 loads the index register in every state. A write strobe to 0xA79 is a data write to the indexed register. A write to index 0x00 in Isolation or Config sets the read port to address {2'b00, data, 2'b11}. A read of index 0x00 gets no response.
- R4: A write to index 0x03 is a wake command. It is accepted in Sleep, Isolation and Config. In Sleep, data equal to the CSN moves the card to Isolation when the data is 0x00 and to Config otherwise. In Isolation or Config, data that differs from the CSN sends the card to Sleep. Every accepted wake pulses `res_ptr_clr` for one cycle.
- R5: In Isolation, a read of index 0x01 returns 0x00 with `rd_ack` and pulses `iso_compare` for one cycle. `iso_fail` in Isolation moves the card to Sleep, and any data write in that same cycle is discarded.
- R6: A data write to index 0x06 in Isolation or Config stores the data as the CSN. From Isolation it also moves the card to Config. In Config, index 0x06 reads back the CSN.
- R7: Index 0x02 is the write-only configuration-control command. It is accepted in Sleep, Isolation and Config, and its bits act only for the cycle of the write. Bit 0 pulses `ldev_reset` and keeps the CSN. Bit 1 returns the card to Wait-for-Key and keeps the CSN. Bit 2 clears the CSN to 0x00.
- R8: In Config, a write to index 0x07 selects the logical device when the data is below NUM_LDEV. A larger value is ignored. Index 0x07 reads back the selection. With NUM_LDEV = 1 the selection is always 0.
- R9: A read strobe to the read port gives `rd_ack` and `rd_data` one cycle later. Reads are answered only in Isolation (index 0x01 only) and in Config. In Config an unimplemented index returns 0x00. A strobe to any other address gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_ok | input | 1 | Initiation key recognised (one-cycle strobe) |
| iso_fail | input | 1 | Serial-identification compare lost (one-cycle strobe) |
| wr_stb | input | 1 | I/O write strobe |
| rd_stb | input | 1 | I/O read strobe |
| bus_addr | input | 12 | I/O address of the access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_ack |
| rd_ack | output | 1 | Read answered, one cycle after rd_stb |
| card_state | output | 2 | Card state (encoding in R1) |
| csn | output | 8 | Current card select number |
| ldev_sel | output | 8 | Selected logical device |
| ldev_reset | output | 1 | Pulse: reset all logical devices |
| res_ptr_clr | output | 1 | Pulse: clear the resource-data byte pointer |
| iso_compare | output | 1 | Pulse: compare one identification bit |

## Verification
Properties are evaluated on every cycle for the state rules that need no history beyond one cycle:
- Wait-for-Key holds unless a key arrives, and it can exit only to Sleep.
- A compare failure always ends Isolation.
- A compare request or read answer only follows the states allowed to give them.
- The device selection stays in range.

Only the scenarios show the following:
- The command meanings: the wake outcomes as a function of the data and the CSN, the configuration-control bits acting together, and CSN retention.
- Relocation of the read port, the silent read of index 0x00, and priority between a compare failure and a same-cycle write.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

    typedef enum logic [1:0] {
        ST_WFK   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_ISO   = 2'd2,
        ST_CFG   = 2'd3
    } card_st_e;

    localparam logic [7:0] IX_RDPORT = 8'h00;
    localparam logic [7:0] IX_SERIAL = 8'h01;
    localparam logic [7:0] IX_CTRL   = 8'h02;
    localparam logic [7:0] IX_WAKE   = 8'h03;
    localparam logic [7:0] IX_CSN    = 8'h06;
    localparam logic [7:0] IX_LDEV   = 8'h07;

    localparam int CTL_LDRST = 0;
    localparam int CTL_WFK   = 1;
    localparam int CTL_CSN0  = 2;

    typedef struct packed {
        card_st_e   st;
        logic [7:0] idx;
        logic [7:0] csn;
        logic [7:0] rdp;
        logic [7:0] ldev;
        logic       ldev_rst;
        logic       ptr_clr;
        logic       iso_cmp;
    } exec_regs_t;

    typedef struct packed {
        logic       ack;
        logic [7:0] data;
    } rd_regs_t;

endpackage

// File: rtl/pnp_port_decode.sv
module pnp_port_decode #(
    parameter logic [11:0] IDX_ADDR = 12'h279,
    parameter logic [11:0] DAT_ADDR = 12'hA79
) (
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [11:0] addr,
    input  logic [7:0]  rdp,
    output logic        idx_wr,
    output logic        dat_wr,
    output logic        rd_hit
);
    logic [11:0] rd_addr;

    always_comb begin
        rd_addr = {2'b00, rdp, 2'b11};
        idx_wr  = wr_stb && (addr == IDX_ADDR);
        dat_wr  = wr_stb && (addr == DAT_ADDR);
        rd_hit  = rd_stb && (addr == rd_addr);
    end
endmodule

// File: rtl/pnp_cmd_exec.sv
module pnp_cmd_exec
    import pnp_cfg_pkg::*;
#(
    parameter int NUM_LDEV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_ok,
    input  logic       iso_fail,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic       rd_hit,
    input  logic [7:0] wdata,
    output card_st_e   st_o,
    output logic [7:0] idx_o,
    output logic [7:0] csn_o,
    output logic [7:0] rdp_o,
    output logic [7:0] ldev_o,
    output logic       ldev_rst_o,
    output logic       ptr_clr_o,
    output logic       iso_cmp_o
);
    localparam bit MULTI_DEV = (NUM_LDEV > 1);

    exec_regs_t r_d, r_q;
    logic       in_ic;
    logic       wr_ok;

    always_comb begin
        r_d          = r_q;
        r_d.ldev_rst = 1'b0;
        r_d.ptr_clr  = 1'b0;
        r_d.iso_cmp  = 1'b0;
        in_ic        = (r_q.st == ST_ISO) || (r_q.st == ST_CFG);

        wr_ok = 1'b0;
        if (dat_wr && !(r_q.st == ST_ISO && iso_fail)) begin
            unique case (r_q.idx)
                IX_CTRL, IX_WAKE:  wr_ok = (r_q.st != ST_WFK);
                IX_RDPORT, IX_CSN: wr_ok = in_ic;
                IX_LDEV:           wr_ok = MULTI_DEV && (r_q.st == ST_CFG)
                                           && (int'(wdata) < NUM_LDEV);
                default:           wr_ok = 1'b0;
            endcase
        end

        if (idx_wr)
            r_d.idx = wdata;

        if (key_ok && r_q.st == ST_WFK)
            r_d.st = ST_SLEEP;

        if (r_q.st == ST_ISO && iso_fail)
            r_d.st = ST_SLEEP;

        if (rd_hit && r_q.st == ST_ISO && r_q.idx == IX_SERIAL)
            r_d.iso_cmp = 1'b1;

        if (wr_ok) begin
            unique case (r_q.idx)
                IX_RDPORT: r_d.rdp = wdata;
                IX_WAKE: begin
                    r_d.ptr_clr = 1'b1;
                    if (r_q.st == ST_SLEEP) begin
                        if (wdata == r_q.csn)
                            r_d.st = (wdata == 8'h00) ? ST_ISO : ST_CFG;
                    end else if (wdata != r_q.csn) begin
                        r_d.st = ST_SLEEP;
                    end
                end
                IX_CSN: begin
                    r_d.csn = wdata;
                    if (r_q.st == ST_ISO)
                        r_d.st = ST_CFG;
                end
                IX_LDEV: r_d.ldev = wdata;
                IX_CTRL: begin
                    r_d.ldev_rst = wdata[CTL_LDRST];
                    if (wdata[CTL_WFK])
                        r_d.st = ST_WFK;
                    if (wdata[CTL_CSN0])
                        r_d.csn = 8'h00;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_WFK, idx: 8'h00, csn: 8'h00, rdp: 8'h00,
                     ldev: 8'h00, ldev_rst: 1'b0, ptr_clr: 1'b0, iso_cmp: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_o       = r_q.st;
    assign idx_o      = r_q.idx;
    assign csn_o      = r_q.csn;
    assign rdp_o      = r_q.rdp;
    assign ldev_o     = r_q.ldev;
    assign ldev_rst_o = r_q.ldev_rst;
    assign ptr_clr_o  = r_q.ptr_clr;
    assign iso_cmp_o  = r_q.iso_cmp;

    p_wfk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WFK && !key_ok) |=> (r_q.st == ST_WFK));

    p_wfk_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WFK) |=> (r_q.st == ST_WFK || r_q.st == ST_SLEEP));

    p_iso_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ISO && iso_fail) |=> (r_q.st == ST_SLEEP));

    p_iso_cmp_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.iso_cmp |-> ($past(r_q.st) == ST_ISO));

    p_ldev_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(r_q.ldev) < NUM_LDEV);
endmodule

// File: rtl/pnp_read_resp.sv
module pnp_read_resp
    import pnp_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_hit,
    input  card_st_e   st,
    input  logic [7:0] idx,
    input  logic [7:0] csn,
    input  logic [7:0] ldev,
    output logic       ack_o,
    output logic [7:0] data_o
);
    rd_regs_t rr_d, rr_q;

    always_comb begin
        rr_d = '{ack: 1'b0, data: 8'h00};
        if (rd_hit) begin
            if (st == ST_ISO) begin
                rr_d.ack = (idx == IX_SERIAL);
            end else if (st == ST_CFG) begin
                rr_d.ack = (idx != IX_RDPORT);
                unique case (idx)
                    IX_CSN:  rr_d.data = csn;
                    IX_LDEV: rr_d.data = ldev;
                    default: rr_d.data = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '{ack: 1'b0, data: 8'h00};
        else
            rr_q <= rr_d;
    end

    assign ack_o  = rr_q.ack;
    assign data_o = rr_q.data;

    p_ack_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rr_q.ack |-> ($past(st) == ST_ISO || $past(st) == ST_CFG));
endmodule

// File: rtl/pnp_card_cfg.sv
module pnp_card_cfg
    import pnp_cfg_pkg::*;
#(
    parameter int          NUM_LDEV = 2,
    parameter logic [11:0] IDX_ADDR = 12'h279,
    parameter logic [11:0] DAT_ADDR = 12'hA79
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_ok,
    input  logic        iso_fail,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [11:0] bus_addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        rd_ack,
    output logic [1:0]  card_state,
    output logic [7:0]  csn,
    output logic [7:0]  ldev_sel,
    output logic        ldev_reset,
    output logic        res_ptr_clr,
    output logic        iso_compare
);
    logic       idx_wr, dat_wr, rd_hit;
    card_st_e   st;
    logic [7:0] idx, csn_int, rdp, ldev_raw, ldev_eff;

    pnp_port_decode #(.IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)) u_dec (
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .addr   (bus_addr),
        .rdp    (rdp),
        .idx_wr (idx_wr),
        .dat_wr (dat_wr),
        .rd_hit (rd_hit)
    );

    pnp_cmd_exec #(.NUM_LDEV(NUM_LDEV)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_ok     (key_ok),
        .iso_fail   (iso_fail),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .rd_hit     (rd_hit),
        .wdata      (wr_data),
        .st_o       (st),
        .idx_o      (idx),
        .csn_o      (csn_int),
        .rdp_o      (rdp),
        .ldev_o     (ldev_raw),
        .ldev_rst_o (ldev_reset),
        .ptr_clr_o  (res_ptr_clr),
        .iso_cmp_o  (iso_compare)
    );

    generate
        if (NUM_LDEV > 1) begin : g_multi
            assign ldev_eff = ldev_raw;
        end else begin : g_single
            assign ldev_eff = 8'h00;
        end
    endgenerate

    pnp_read_resp u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_hit),
        .st     (st),
        .idx    (idx),
        .csn    (csn_int),
        .ldev   (ldev_eff),
        .ack_o  (rd_ack),
        .data_o (rd_data)
    );

    assign card_state = st;
    assign csn        = csn_int;
    assign ldev_sel   = ldev_eff;
endmodule

// File: tb/pnp_card_cfg_tb.sv
module pnp_card_cfg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_ok = 1'b0, iso_fail = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data, csn, ldev_sel;
    logic        rd_ack, ldev_reset, res_ptr_clr, iso_compare;
    logic [1:0]  card_state;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pnp_card_cfg dut_i (
        .clk(clk), .rst_n(rst_n), .key_ok(key_ok), .iso_fail(iso_fail),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .bus_addr(bus_addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_ack(rd_ack), .card_state(card_state), .csn(csn),
        .ldev_sel(ldev_sel), .ldev_reset(ldev_reset), .res_ptr_clr(res_ptr_clr),
        .iso_compare(iso_compare)
    );

    localparam logic [2:0] OP_IDX = 3'd0, OP_DAT = 3'd1, OP_RD = 3'd2,
                           OP_KEY = 3'd3, OP_ISOF = 3'd4, OP_IDLE = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] addr;
        logic [7:0]  dat;
        logic [1:0]  st;
        logic        ack;
        logic [7:0]  rdv;
        logic [7:0]  csn;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t TBL [NV] = '{
        '{OP_IDX,  12'h000, 8'h06, 2'd0, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h55, 2'd0, 1'b0, 8'h00, 8'h00},
        '{OP_RD,   12'h003, 8'h00, 2'd0, 1'b0, 8'h00, 8'h00},
        '{OP_KEY,  12'h000, 8'h00, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_KEY,  12'h000, 8'h00, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_IDX,  12'h000, 8'h03, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h05, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h00, 2'd2, 1'b0, 8'h00, 8'h00},
        '{OP_IDX,  12'h000, 8'h01, 2'd2, 1'b0, 8'h00, 8'h00},
        '{OP_RD,   12'h003, 8'h00, 2'd2, 1'b1, 8'h00, 8'h00},
        '{OP_ISOF, 12'h000, 8'h00, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_IDX,  12'h000, 8'h03, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h00, 2'd2, 1'b0, 8'h00, 8'h00},
        '{OP_IDX,  12'h000, 8'h06, 2'd2, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h2A, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_RD,   12'h003, 8'h00, 2'd3, 1'b1, 8'h2A, 8'h2A},
        '{OP_IDX,  12'h000, 8'h00, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_DAT,  12'h000, 8'h80, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_RD,   12'h003, 8'h00, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_RD,   12'h203, 8'h00, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_IDX,  12'h000, 8'h07, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_DAT,  12'h000, 8'h01, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_RD,   12'h203, 8'h00, 2'd3, 1'b1, 8'h01, 8'h2A},
        '{OP_DAT,  12'h000, 8'h05, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_RD,   12'h203, 8'h00, 2'd3, 1'b1, 8'h01, 8'h2A},
        '{OP_IDX,  12'h000, 8'h25, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_RD,   12'h203, 8'h00, 2'd3, 1'b1, 8'h00, 8'h2A},
        '{OP_IDX,  12'h000, 8'h03, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_DAT,  12'h000, 8'h11, 2'd1, 1'b0, 8'h00, 8'h2A},
        '{OP_DAT,  12'h000, 8'h2A, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_IDX,  12'h000, 8'h02, 2'd3, 1'b0, 8'h00, 8'h2A},
        '{OP_DAT,  12'h000, 8'h04, 2'd3, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h02, 2'd0, 1'b0, 8'h00, 8'h00},
        '{OP_RD,   12'h203, 8'h00, 2'd0, 1'b0, 8'h00, 8'h00},
        '{OP_KEY,  12'h000, 8'h00, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_IDX,  12'h000, 8'h03, 2'd1, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h00, 2'd2, 1'b0, 8'h00, 8'h00},
        '{OP_IDX,  12'h000, 8'h02, 2'd2, 1'b0, 8'h00, 8'h00},
        '{OP_DAT,  12'h000, 8'h02, 2'd0, 1'b0, 8'h00, 8'h00}
    };

    // One bus cycle: drive at negedge, posedge captures, outputs checked at next negedge.
    task automatic apply(input logic [2:0] op, input logic [11:0] a,
                         input logic [7:0] d, input logic isof);
        @(negedge clk);
        wr_stb   = (op == OP_IDX) || (op == OP_DAT);
        rd_stb   = (op == OP_RD);
        key_ok   = (op == OP_KEY);
        iso_fail = (op == OP_ISOF) || isof;
        bus_addr = (op == OP_IDX) ? 12'h279 : (op == OP_DAT) ? 12'hA79 : a;
        wr_data  = d;
        @(negedge clk);
        wr_stb = 0; rd_stb = 0; key_ok = 0; iso_fail = 0;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "state", {6'd0, card_state}, 8'h00);
        chk("R1", "csn", csn, 8'h00);
        chk("R1", "ldev", ldev_sel, 8'h00);
        chk("R1", "ack", {7'd0, rd_ack}, 8'h00);

        // R2 R3 R4 R5 R6 R7 R8 R9 table walk
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].op, TBL[i].addr, TBL[i].dat, 1'b0);
            chk("R2/R4/R6/R7 row", $sformatf("%0d state", i), {6'd0, card_state}, {6'd0, TBL[i].st});
            chk("R6/R7 row", $sformatf("%0d csn", i), csn, TBL[i].csn);
            chk("R3/R9 row", $sformatf("%0d ack", i), {7'd0, rd_ack}, {7'd0, TBL[i].ack});
            if (TBL[i].ack)
                chk("R5/R8/R9 row", $sformatf("%0d data", i), rd_data, TBL[i].rdv);
        end

        // R7 bit 0: device reset pulse, CSN kept, pulse lasts one cycle
        apply(OP_KEY, 0, 0, 0);
        apply(OP_IDX, 0, 8'h03, 0);
        apply(OP_DAT, 0, 8'h00, 0);
        apply(OP_IDX, 0, 8'h06, 0);
        apply(OP_DAT, 0, 8'h33, 0);
        apply(OP_IDX, 0, 8'h02, 0);
        apply(OP_DAT, 0, 8'h01, 0);
        chk("R7", "ldev_reset", {7'd0, ldev_reset}, 8'h01);
        chk("R7", "csn kept", csn, 8'h33);
        chk("R7", "state", {6'd0, card_state}, 8'h03);
        apply(OP_IDLE, 0, 0, 0);
        chk("R7", "ldev_reset self-clear", {7'd0, ldev_reset}, 8'h00);

        // R4 matching wake in Config: stays, pointer clear pulses
        apply(OP_IDX, 0, 8'h03, 0);
        apply(OP_DAT, 0, 8'h33, 0);
        chk("R4", "ptr_clr", {7'd0, res_ptr_clr}, 8'h01);
        chk("R4", "state", {6'd0, card_state}, 8'h03);

        // R5 compare request and iso_fail against a same-cycle CSN write
        apply(OP_IDX, 0, 8'h02, 0);
        apply(OP_DAT, 0, 8'h04, 0);
        apply(OP_DAT, 0, 8'h02, 0);
        apply(OP_KEY, 0, 0, 0);
        apply(OP_IDX, 0, 8'h03, 0);
        apply(OP_DAT, 0, 8'h00, 0);
        apply(OP_IDX, 0, 8'h01, 0);
        apply(OP_RD, 12'h203, 0, 0);
        chk("R5", "iso_compare", {7'd0, iso_compare}, 8'h01);
        chk("R5", "ack", {7'd0, rd_ack}, 8'h01);
        apply(OP_IDX, 0, 8'h06, 0);
        apply(OP_DAT, 0, 8'h44, 1'b1);
        chk("R5", "state after fail", {6'd0, card_state}, 8'h01);
        chk("R5", "csn write dropped", csn, 8'h00);

        // R1 reset mid-run restores read port 0x003
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1", "state after reset", {6'd0, card_state}, 8'h00);
        chk("R1", "ldev after reset", ldev_sel, 8'h00);
        apply(OP_KEY, 0, 0, 0);
        apply(OP_IDX, 0, 8'h03, 0);
        apply(OP_DAT, 0, 8'h00, 0);
        apply(OP_IDX, 0, 8'h01, 0);
        apply(OP_RD, 12'h003, 0, 0);
        chk("R1", "read port default ack", {7'd0, rd_ack}, 8'h01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule